// File: doc/BRIEF.md
# Two-Phase Address Multiplexed Bus Sequencer

This block runs single read and write accesses on an external memory bus that carries address and data on one set of pins. Each access drives the full address in two halves, the upper half first and then the lower half. The level of the output-enable strobe tells the device which half is on the bus: low means the upper half and high means the lower half. After the address, a write drives its data and a read turns the bus around to capture data. All strobes are active low.

A host places one request at a time on a valid/ready interface. A request gives the direction, the address and the write data. When the access ends, the block returns the read data with a one-cycle done pulse. Each strobe edge sits at its own programmed cycle count. One counter, cleared at launch, measures every count, so the address-valid and output-enable strobes can each pulse twice in one access. The configuration inputs must stay stable while an access runs.

Counts below are in cycles since launch. Cycle `t` is the cycle in which the counter holds `t`, and the first cycle after the accepting edge is `t = 0`. A window `[on, off)` covers the cycles with `on <= t < off`.

Top module: `aad_mux_seq`

## Requirements
- R1: After reset, `cs_n`, `adv_n`, `oe_n` and `we_n` are 1, `req_ready` is 1, `rsp_done` is 0, `bus_drive` is 1 and `bus_out` is 0.
- R2: `cs_n` is 0 for every cycle from `t = 0` up to and including `t = T_END`. For a read, `T_END = max(cfg_adv2_off, cfg_oe2_off)`; for a write, `T_END = max(cfg_adv2_off, cfg_we_off)`. In the next cycle `rsp_done` is 1 for exactly one cycle and `cs_n` is 1.
- R3: In both reads and writes, `adv_n` is 0 exactly in the windows `[cfg_adv1_on, cfg_adv1_off)` and `[cfg_adv2_on, cfg_adv2_off)`.
- R4: In a read, `oe_n` is 0 exactly in `[cfg_oe1_on, cfg_oe1_off)` and `[cfg_oe2_on, cfg_oe2_off)`. In a write, `oe_n` is 0 only in `[cfg_oe1_on, cfg_oe1_off)`.
- R5: In a write, `we_n` is 0 exactly in `[cfg_we_on, cfg_we_off)`. `we_n` stays 1 throughout every read.
- R6: For `t < cfg_oe1_off`, `bus_out` carries `req_addr[2*BUS_W-1:BUS_W]`. From `cfg_oe1_off` until the data phase it carries `req_addr[BUS_W-1:0]`.
- R7: In a write, `bus_drive` is 1 for the whole access, and `bus_out` carries `req_wdata` from `t = cfg_we_on` onwards.
- R8: In a read, `bus_drive` is 0 from `t = cfg_oe2_on` to the end. The block samples `bus_in` in cycle `t = cfg_oe2_off - 1` and shows the sample on `rsp_rdata` from the done cycle onwards.
- R9: Outside an access, `bus_drive` is 1 and `bus_out` carries the most recently read value (0 if nothing has been read). A write does not change that value.
- R10: `req_ready` is 0 from launch until the done cycle. A request presented in that time is ignored and does not disturb the access in progress.
- R11: A request presented during the done cycle is accepted at the next edge, and its `t = 0` cycle follows the done cycle directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*BUS_W | Access address |
| req_wdata | input | BUS_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | BUS_W | Last data read |
| cfg_adv1_on | input | 3 | First address-valid assert cycle |
| cfg_adv1_off | input | 3 | First address-valid release cycle |
| cfg_adv2_on | input | 4 | Second address-valid assert cycle |
| cfg_adv2_off | input | 5 | Second address-valid release cycle |
| cfg_oe1_on | input | 3 | First output-enable assert cycle |
| cfg_oe1_off | input | 3 | First output-enable release cycle |
| cfg_oe2_on | input | 4 | Read-data output-enable assert cycle |
| cfg_oe2_off | input | 5 | Read-data output-enable release cycle |
| cfg_we_on | input | 4 | Write-enable assert cycle |
| cfg_we_off | input | 5 | Write-enable release cycle |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bus_drive | output | 1 | 1 = block drives the shared bus |
| bus_out | output | BUS_W | Value driven on the shared bus |
| bus_in | input | BUS_W | Value sampled from the shared bus |

## Verification
A wrong counter value or a stale latched command moves a strobe edge, or puts the wrong address half on the bus. This shows up in the first cycle of the access that depends on it. The bench compares every strobe, the drive flag and the bus value in every cycle of every access, so a one-cycle slip is caught at once. A capture at the wrong moment returns the wrong word: the bench drives the read word only inside the second output-enable window, so a misplaced sample shows up as a bad `rsp_rdata` in the done cycle. It also shows up as a bad idle bus value in the cycles after it. A lost request or a wrong busy flag shows up as `req_ready` or `cs_n` mismatching the expected cycle. Stray requests during an access would corrupt the checked address and data.

// File: rtl/aad_pkg.sv
package aad_pkg;
  localparam int T_W = 5;
  typedef logic [T_W-1:0] tick_t;

  function automatic tick_t tick_max(input tick_t a, input tick_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/aad_timer.sv
module aad_timer
  import aad_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  tick_t t_end,
  output logic  busy,
  output tick_t cnt,
  output tick_t t_nxt,
  output logic  fin
);
  assign fin   = busy && (cnt == t_end);
  assign t_nxt = start ? '0 : tick_t'(cnt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= tick_t'(cnt + 1'b1);
    end
  end
endmodule

// File: rtl/aad_window.sv
module aad_window
  import aad_pkg::*;
(
  input  tick_t t,
  input  tick_t on_t,
  input  tick_t off_t,
  output logic  hit
);
  assign hit = (t >= on_t) && (t < off_t);
endmodule

// File: rtl/aad_bus_sel.sv
module aad_bus_sel
  import aad_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  tick_t            t,
  input  logic             wr,
  input  logic [BUS_W-1:0] addr_hi,
  input  logic [BUS_W-1:0] addr_lo,
  input  logic [BUS_W-1:0] wdata,
  input  tick_t            lo_from,
  input  tick_t            rd_from,
  input  tick_t            wd_from,
  output logic             drive,
  output logic [BUS_W-1:0] val
);
  always_comb begin
    drive = wr || (t < rd_from);
    if (t < lo_from)             val = addr_hi;
    else if (wr && t >= wd_from) val = wdata;
    else                         val = addr_lo;
  end
endmodule

// File: rtl/aad_mux_seq.sv
module aad_mux_seq
  import aad_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [2*BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0]   req_wdata,
  output logic               rsp_done,
  output logic [BUS_W-1:0]   rsp_rdata,
  input  logic [2:0]         cfg_adv1_on,
  input  logic [2:0]         cfg_adv1_off,
  input  logic [3:0]         cfg_adv2_on,
  input  logic [4:0]         cfg_adv2_off,
  input  logic [2:0]         cfg_oe1_on,
  input  logic [2:0]         cfg_oe1_off,
  input  logic [3:0]         cfg_oe2_on,
  input  logic [4:0]         cfg_oe2_off,
  input  logic [3:0]         cfg_we_on,
  input  logic [4:0]         cfg_we_off,
  output logic               cs_n,
  output logic               adv_n,
  output logic               oe_n,
  output logic               we_n,
  output logic               bus_drive,
  output logic [BUS_W-1:0]   bus_out,
  input  logic [BUS_W-1:0]   bus_in
);
  localparam int ADDR_W = 2 * BUS_W;
  localparam int NWIN   = 5;
  localparam int W_ADV1 = 0;
  localparam int W_ADV2 = 1;
  localparam int W_OE1  = 2;
  localparam int W_OE2  = 3;
  localparam int W_WE   = 4;

  logic              busy, fin, start, run;
  tick_t             cnt, t_nxt, t_end;
  logic              cmd_wr_q, cmd_wr_n;
  logic [ADDR_W-1:0] cmd_addr_q, cmd_addr_n;
  logic [BUS_W-1:0]  cmd_wd_q, cmd_wd_n;
  logic [BUS_W-1:0]  rdata_q;
  logic              sel_drive;
  logic [BUS_W-1:0]  sel_val;
  logic              capture;

  tick_t [NWIN-1:0] on_v, off_v;
  logic  [NWIN-1:0] hit;

  assign on_v[W_ADV1]  = tick_t'(cfg_adv1_on);
  assign off_v[W_ADV1] = tick_t'(cfg_adv1_off);
  assign on_v[W_ADV2]  = tick_t'(cfg_adv2_on);
  assign off_v[W_ADV2] = tick_t'(cfg_adv2_off);
  assign on_v[W_OE1]   = tick_t'(cfg_oe1_on);
  assign off_v[W_OE1]  = tick_t'(cfg_oe1_off);
  assign on_v[W_OE2]   = tick_t'(cfg_oe2_on);
  assign off_v[W_OE2]  = tick_t'(cfg_oe2_off);
  assign on_v[W_WE]    = tick_t'(cfg_we_on);
  assign off_v[W_WE]   = tick_t'(cfg_we_off);

  assign req_ready = !busy;
  assign start     = req_valid && !busy;
  assign run       = start || (busy && !fin);
  assign t_end     = cmd_wr_q ? tick_max(off_v[W_ADV2], off_v[W_WE])
                              : tick_max(off_v[W_ADV2], off_v[W_OE2]);

  assign cmd_wr_n   = start ? req_write : cmd_wr_q;
  assign cmd_addr_n = start ? req_addr  : cmd_addr_q;
  assign cmd_wd_n   = start ? req_wdata : cmd_wd_q;

  assign capture = busy && !fin && !cmd_wr_q &&
                   (tick_t'(cnt + 1'b1) == off_v[W_OE2]);

  aad_timer u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .t_end (t_end),
    .busy  (busy),
    .cnt   (cnt),
    .t_nxt (t_nxt),
    .fin   (fin)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    aad_window u_win (
      .t     (t_nxt),
      .on_t  (on_v[i]),
      .off_t (off_v[i]),
      .hit   (hit[i])
    );
  end

  aad_bus_sel #(.BUS_W(BUS_W)) u_sel (
    .t       (t_nxt),
    .wr      (cmd_wr_n),
    .addr_hi (cmd_addr_n[ADDR_W-1:BUS_W]),
    .addr_lo (cmd_addr_n[BUS_W-1:0]),
    .wdata   (cmd_wd_n),
    .lo_from (off_v[W_OE1]),
    .rd_from (on_v[W_OE2]),
    .wd_from (on_v[W_WE]),
    .drive   (sel_drive),
    .val     (sel_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_wr_q   <= 1'b0;
      cmd_addr_q <= '0;
      cmd_wd_q   <= '0;
      rdata_q    <= '0;
      rsp_done   <= 1'b0;
      cs_n       <= 1'b1;
      adv_n      <= 1'b1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      bus_drive  <= 1'b1;
      bus_out    <= '0;
    end else begin
      cmd_wr_q   <= cmd_wr_n;
      cmd_addr_q <= cmd_addr_n;
      cmd_wd_q   <= cmd_wd_n;
      rsp_done   <= fin;
      if (capture) rdata_q <= bus_in;
      if (run) begin
        cs_n      <= 1'b0;
        adv_n     <= !(hit[W_ADV1] || hit[W_ADV2]);
        oe_n      <= !(hit[W_OE1] || (hit[W_OE2] && !cmd_wr_n));
        we_n      <= !(hit[W_WE] && cmd_wr_n);
        bus_drive <= sel_drive;
        bus_out   <= sel_val;
      end else begin
        cs_n      <= 1'b1;
        adv_n     <= 1'b1;
        oe_n      <= 1'b1;
        we_n      <= 1'b1;
        bus_drive <= 1'b1;
        bus_out   <= rdata_q;
      end
    end
  end

  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/aad_mux_seq_chk.sv
module aad_mux_seq_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [BUS_W-1:0] rsp_rdata,
  input logic             cs_n,
  input logic             adv_n,
  input logic             oe_n,
  input logic             we_n,
  input logic             bus_drive
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R2
  AST_DONE_ENDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> cs_n && !$past(cs_n)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (adv_n && oe_n && we_n)); // R3
  AST_READY_MATCHES_SELECT: assert property (@(posedge clk) disable iff (rst)
    req_ready == cs_n); // R10
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> bus_drive); // R7
  AST_RELEASE_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> !cs_n); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> $past(!cs_n)); // R8
endmodule

bind aad_mux_seq aad_mux_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .cs_n      (cs_n),
  .adv_n     (adv_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .bus_drive (bus_drive)
);

// File: tb/sim_aad_mux_seq.sv
`timescale 1ns/1ps
module sim_aad_mux_seq;
  localparam int BW = 16;

  logic          clk = 0;
  logic          rst = 1;
  logic          req_valid = 0, req_write = 0;
  logic          req_ready, rsp_done;
  logic [2*BW-1:0] req_addr = '0;
  logic [BW-1:0] req_wdata = '0, rsp_rdata, bus_out, bus_in = '0;
  logic [2:0]    a1on, a1off, o1on, o1off;
  logic [3:0]    a2on, o2on, weon;
  logic [4:0]    a2off, o2off, weoff;
  logic          cs_n, adv_n, oe_n, we_n, bus_drive;

  int checks = 0;
  int errors = 0;
  logic [BW-1:0] last_rd = '0;

  always #10 clk = ~clk;

  aad_mux_seq #(.BUS_W(BW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_adv1_on(a1on), .cfg_adv1_off(a1off), .cfg_adv2_on(a2on),
    .cfg_adv2_off(a2off), .cfg_oe1_on(o1on), .cfg_oe1_off(o1off),
    .cfg_oe2_on(o2on), .cfg_oe2_off(o2off), .cfg_we_on(weon),
    .cfg_we_off(weoff), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .bus_drive(bus_drive), .bus_out(bus_out), .bus_in(bus_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_win(input int t, input int on, input int off);
    return (t >= on) && (t < off);
  endfunction

  function automatic int end_of(input bit wr);
    int x = wr ? int'(weoff) : int'(o2off);
    return (int'(a2off) > x) ? int'(a2off) : x;
  endfunction

  function automatic bit exp_adv_n(input int t);
    return !(in_win(t, a1on, a1off) || in_win(t, a2on, a2off));
  endfunction

  function automatic bit exp_oe_n(input int t, input bit wr);
    return !(in_win(t, o1on, o1off) || (!wr && in_win(t, o2on, o2off)));
  endfunction

  function automatic bit exp_we_n(input int t, input bit wr);
    return !(wr && in_win(t, weon, weoff));
  endfunction

  function automatic bit exp_drive(input int t, input bit wr);
    return wr || (t < int'(o2on));
  endfunction

  function automatic logic [BW-1:0] exp_bus(input int t, input bit wr,
      input logic [2*BW-1:0] a, input logic [BW-1:0] wd);
    if (t < int'(o1off)) return a[2*BW-1:BW];
    if (wr && t >= int'(weon)) return wd;
    return a[BW-1:0];
  endfunction

  task automatic rand_cfg();
    int v;
    a1on  = 3'($urandom_range(0, 2));
    a1off = 3'(a1on + $urandom_range(1, 3));
    o1on  = 3'($urandom_range(0, 2));
    v = (int'(a1off) > int'(o1on) + 1) ? int'(a1off) : int'(o1on) + 1;
    o1off = 3'($urandom_range(v, 7));
    a2on  = 4'(o1off + $urandom_range(0, 3));
    a2off = 5'(a2on + $urandom_range(1, 4));
    o2on  = 4'(a2off + $urandom_range(0, 1));
    o2off = 5'(o2on + $urandom_range(1, 6));
    weon  = 4'(a2off + $urandom_range(0, 1));
    weoff = 5'(weon + $urandom_range(1, 6));
  endtask

  // Entered and left just after a falling edge.
  task automatic do_access(input bit wr, input logic [2*BW-1:0] a,
      input logic [BW-1:0] wd, input logic [BW-1:0] rv, input bit noisy,
      input bit b2b);
    int te = end_of(wr);
    check("R10 ready before launch", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (b2b) check("R11 back-to-back start", cs_n, 0);
    for (int t = 0; t <= te; t++) begin
      if (t == 0) begin
        req_valid = noisy; req_write = ~wr; req_addr = ~a; req_wdata = ~wd;
      end
      if (t == te) req_valid = 0;
      bus_in = in_win(t, o2on, o2off) ? rv : ~rv;
      check("R2 cs_n", cs_n, 0);
      check("R10 ready low", req_ready, 0);
      check("R3 adv_n", adv_n, exp_adv_n(t));
      check("R4 oe_n", oe_n, exp_oe_n(t, wr));
      check("R5 we_n", we_n, exp_we_n(t, wr));
      check(wr ? "R7 drive" : "R8 drive", bus_drive, exp_drive(t, wr));
      if (exp_drive(t, wr))
        check((wr && t >= int'(weon)) ? "R7 data" : "R6 address",
              bus_out, exp_bus(t, wr, a, wd));
      check("R2 no early done", rsp_done, 0);
      @(negedge clk);
    end
    if (!wr) last_rd = rv;
    check("R2 done pulse", rsp_done, 1);
    check("R2 cs_n released", cs_n, 1);
    check("R8 rdata", rsp_rdata, last_rd);
    check("R9 idle drive", bus_drive, 1);
    check("R9 idle bus", bus_out, last_rd);
    check("R3 idle adv", {adv_n, oe_n, we_n}, 3'b111);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2 done one cycle", rsp_done, 0);
      check("R9 idle bus", bus_out, last_rd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    a1on = 0; a1off = 1; o1on = 0; o1off = 2; a2on = 2; a2off = 3;
    o2on = 3; o2off = 4; weon = 3; weoff = 5;
    repeat (3) @(negedge clk);
    check("R1 cs_n", cs_n, 1);
    check("R1 strobes", {adv_n, oe_n, we_n}, 3'b111);
    check("R1 ready", req_ready, 1);
    check("R1 done", rsp_done, 0);
    check("R1 drive", bus_drive, 1);
    check("R1 bus", bus_out, 0);
    rst = 0;
    @(negedge clk);
    // Directed: tight timing, read, write, then a noisy back-to-back pair.
    do_access(0, 32'hA5A5_1234, 16'h0000, 16'hBEEF, 0, 0);
    gap(2);
    do_access(1, 32'h0F0F_C3C3, 16'h5A5A, 16'h0000, 0, 0);
    check("R9 write keeps read value", bus_out, 16'hBEEF);
    do_access(0, 32'h1111_2222, 16'h0000, 16'h7777, 1, 1);
    do_access(1, 32'h3333_4444, 16'h9999, 16'h0000, 1, 1);
    gap(1);
    // Directed: longest windows.
    a1on = 0; a1off = 7; o1on = 0; o1off = 7; a2on = 15; a2off = 16;
    o2on = 15; o2off = 31; weon = 15; weoff = 31;
    do_access(0, 32'hFFFF_0001, 16'h0000, 16'hC001, 0, 0);
    do_access(1, 32'h8000_7FFF, 16'hD00D, 16'h0000, 0, 1);
    gap(1);
    for (int n = 0; n < 300; n++) begin
      if (n % 8 == 0) rand_cfg();
      do_access(1'($urandom_range(0, 1)), $urandom, 16'($urandom),
                16'($urandom), 1'($urandom_range(0, 1)), n % 8 != 0);
      if (n % 8 == 7 || $urandom_range(0, 2) == 0) gap($urandom_range(1, 3));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule